// File: doc/BRIEF.md
# Tearing-Effect Line Trigger

This block watches the single tearing-effect wire that a display panel drives and turns it into a transfer start. The panel signals the start of a frame with a long pulse and the start of each scan line with a short pulse on the same wire. The block tells the two apart by pulse length alone, measured in clock ticks. After each frame pulse it counts line pulses, and it emits a one-cycle trigger when the scan position reaches a programmed line. A pixel mover can then start writing the frame without tearing.

Software programs two width thresholds, an active-level choice for each pulse kind, a 2-bit wait mode and an 11-bit target line. The wire is first brought into the clock domain by a two-flop synchroniser. Threshold settings that cannot be told apart, or that are too short, raise an error flag, and no trigger is issued while the flag is set.

Top module: `te_line_sync`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `frame_trigger`, `line_count` and `cfg_error` are all 0.
- R2: A pulse whose active run lasts at least `vs_width` ticks is a frame pulse. It sets `line_count` to 0.
- R3: A pulse lasting at least `hs_width` ticks but fewer than `vs_width` ticks is a line pulse. It adds one to `line_count`. The count saturates at 2047 and stays there on further line pulses.
- R4: A pulse shorter than `hs_width` ticks leaves `line_count` unchanged and produces no trigger.
- R5: `vs_pol_high` and `hs_pol_high` select the active level: 1 for high, 0 for low. Detection works the same way at either level.
- R6: `trig_mode` = 0 (internal start) never produces a trigger.
- R7: `trig_mode` = 1 fires on a frame pulse when `target_line` = 0. It fires on the line pulse that raises `line_count` to `target_line` when `target_line` is not 0.
- R8: `trig_mode` = 2 or 3 fires only on the line pulse that raises `line_count` to `target_line`. With `target_line` = 0 it never fires.
- R9: `frame_trigger` is high for exactly one cycle. It fires at most once per frame.
- R10: `cfg_error` rises one cycle after any of these settings appears: `hs_width` < 2; `vs_width` < 4 with `trig_mode` = 1; `vs_width` < 2 in the other modes; or `hs_width` = `vs_width`. No trigger is issued while `cfg_error` is high.
- R11: No trigger is issued until a frame pulse has been seen since reset.
- R12: A pulse's effect on `frame_trigger` and `line_count` appears right after the fourth rising clock edge following the wire leaving its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| te_in | input | 1 | Tearing-effect wire from the panel, asynchronous |
| vs_pol_high | input | 1 | Frame pulse active level (1 = high) |
| hs_pol_high | input | 1 | Line pulse active level (1 = high) |
| trig_mode | input | 2 | 0 internal, 1 frame-or-line wait, 2/3 line wait |
| hs_width | input | 8 | Minimum line pulse length in ticks |
| vs_width | input | 8 | Minimum frame pulse length in ticks |
| target_line | input | 11 | Line number at which to trigger |
| frame_trigger | output | 1 | One-cycle transfer start |
| line_count | output | 11 | Lines seen since the last frame pulse |
| cfg_error | output | 1 | Illegal threshold settings |

## Verification
The assertions assume that configuration changes only while no pulse is in flight through the synchroniser and width counters. They also assume that pulses are separated by idle gaps long enough for one event to retire before the next begins, which keeps the trigger single-cycle. The stimulus holds both active levels equal, changes polarity only across a reset, and reprograms thresholds and mode only in idle gaps of at least six cycles. Random pulse lengths span glitches, line pulses and frame pulses around the thresholds. Directed cases cover exact latency, saturation at 2047, the error settings and the no-frame-yet case.

// File: rtl/te_sync_pkg.sv
// Package: shared encodings for the tearing-effect line trigger.
// Assumes: nothing; types only.
package te_sync_pkg;

    // Wait mode encoding carried on trig_mode.
    typedef enum logic [1:0] {
        MODE_INTERNAL = 2'd0,
        MODE_FRAME_OR_LINE = 2'd1,
        MODE_LINE_ONLY = 2'd2,
        MODE_LINE_ONLY_ALT = 2'd3
    } te_mode_e;

    // Index of each pulse-kind meter.
    localparam int KIND_FRAME = 0;
    localparam int KIND_LINE = 1;
    localparam int NUM_KINDS = 2;

endpackage

// File: rtl/te_input_sync.sv
// Module: te_input_sync
// Brings the asynchronous panel wire into the clock domain through a
// flop chain. Assumes idle_lvl is the inactive level of the wire, so that
// the chain resets to "no pulse" and reset release creates no false run.
module te_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_lvl,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_q;

    // First stage captures the raw wire.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= idle_lvl;
        else        stg_q[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each further stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[gi] <= idle_lvl;
                else        stg_q[gi] <= stg_q[gi-1];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/te_pulse_meter.sv
// Module: te_pulse_meter
// Counts how many cycles a qualified level stays active. When the level
// drops, it reports the run length for one cycle. The count saturates at
// the top of its range. Assumes active is already synchronised.
module te_pulse_meter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    output logic          end_vld,
    output logic [CW-1:0] end_len
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] run_q;

    // Run counter plus the one-cycle end-of-run report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            end_vld <= 1'b0;
            end_len <= '0;
        end else begin
            end_vld <= 1'b0;
            if (active) begin
                if (run_q != CNT_MAX) run_q <= run_q + CNT_ONE;
            end else if (run_q != '0) begin
                end_vld <= 1'b1;
                end_len <= run_q;
                run_q   <= '0;
            end
        end
    end

    // A report is a single cycle: a new run needs an active cycle first (R4).
    assert_end_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        end_vld |=> !end_vld);

    // A report never carries an empty run (R4).
    assert_end_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        end_vld |-> (end_len != '0));
endmodule

// File: rtl/te_cfg_check.sv
// Module: te_cfg_check
// Flags threshold settings that make the pulse kinds ambiguous or too short
// to resolve. The flag is registered, so it follows the inputs one cycle
// later. Assumes settings are quasi-static.
module te_cfg_check #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] hs_w,
    input  logic [CW-1:0] vs_w,
    input  logic [1:0]    mode,
    output logic          err_q
);
    import te_sync_pkg::*;

    localparam logic [CW-1:0] MIN_LINE      = CW'(2);
    localparam logic [CW-1:0] MIN_FRAME_M1  = CW'(4);
    localparam logic [CW-1:0] MIN_FRAME_OTH = CW'(2);

    te_mode_e      mode_e;
    logic [CW-1:0] min_frame;
    logic          bad_line;
    logic          bad_frame;
    logic          bad_equal;

    assign mode_e = te_mode_e'(mode);

    // Minimum frame width depends on the wait mode.
    always_comb begin
        if (mode_e == MODE_FRAME_OR_LINE) min_frame = MIN_FRAME_M1;
        else                              min_frame = MIN_FRAME_OTH;
    end

    assign bad_line  = (hs_w < MIN_LINE);
    assign bad_frame = (vs_w < min_frame);
    assign bad_equal = (hs_w == vs_w);

    // Register the combined verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_line | bad_frame | bad_equal;
    end

    // Equal thresholds are reported in the following cycle (R10).
    assert_err_on_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_w == vs_w) |=> err_q);

    // A line width below two ticks is reported in the following cycle (R10).
    assert_err_on_short_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_w < MIN_LINE) |=> err_q);
endmodule

// File: rtl/te_line_tracker.sv
// Module: te_line_tracker
// Keeps the line count since the last frame pulse and decides when to fire
// the transfer trigger according to the wait mode. Assumes frame and line
// events are single-cycle and that a frame event wins when both arrive.
module te_line_tracker #(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_evt,
    input  logic          line_evt,
    input  logic [1:0]    mode,
    input  logic [LW-1:0] target,
    input  logic          err_q,
    output logic          trig_q,
    output logic [LW-1:0] cnt_q
);
    import te_sync_pkg::*;

    localparam logic [LW-1:0] LINE_MAX = {LW{1'b1}};
    localparam logic [LW-1:0] LINE_ONE = {{(LW-1){1'b0}}, 1'b1};

    te_mode_e      mode_e;
    logic          seen_q;
    logic [LW-1:0] cnt_next;
    logic          cnt_full;
    logic          frame_fire;
    logic          line_fire;

    assign mode_e   = te_mode_e'(mode);
    assign cnt_full = (cnt_q == LINE_MAX);
    assign cnt_next = cnt_q + LINE_ONE;

    // Fire conditions for each event kind.
    assign frame_fire = !err_q && (mode_e == MODE_FRAME_OR_LINE) && (target == '0);
    assign line_fire  = !err_q && seen_q && (mode_e != MODE_INTERNAL)
                        && !cnt_full && (cnt_next == target);

    // Line counter, frame-seen flag and trigger register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (frame_evt) begin
                cnt_q  <= '0;
                seen_q <= 1'b1;
                trig_q <= frame_fire;
            end else if (line_evt) begin
                if (!cnt_full) cnt_q <= cnt_next;
                trig_q <= line_fire;
            end
        end
    end

    // A frame pulse clears the count (R2).
    assert_frame_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> (cnt_q == '0));

    // A line pulse below saturation steps the count by one (R3).
    assert_line_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt && !frame_evt && !cnt_full) |=> (cnt_q == $past(cnt_q) + LINE_ONE));

    // A saturated count holds (R3).
    assert_line_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_full && !frame_evt) |=> cnt_full);

    // Trigger never lasts two cycles (R9).
    assert_trig_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q);

    // No trigger out of a cycle that had the error flag up (R10).
    assert_no_trig_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> !$past(err_q));

    // Internal mode never fires (R6).
    assert_internal_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> ($past(mode) != 2'd0));

    // Nothing fires before the first frame pulse (R11).
    assert_needs_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> seen_q);
endmodule

// File: rtl/te_line_sync.sv
// Module: te_line_sync (top)
// Tearing-effect line trigger: synchronises the panel wire, measures active
// runs at the frame and line polarities, classifies each run by length and
// drives the line counter and trigger. Assumes thresholds, polarities and
// mode change only while the wire is idle.
module te_line_sync #(
    parameter int WID_W       = 8,
    parameter int LINE_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic              vs_pol_high,
    input  logic              hs_pol_high,
    input  logic [1:0]        trig_mode,
    input  logic [WID_W-1:0]  hs_width,
    input  logic [WID_W-1:0]  vs_width,
    input  logic [LINE_W-1:0] target_line,
    output logic              frame_trigger,
    output logic [LINE_W-1:0] line_count,
    output logic              cfg_error
);
    import te_sync_pkg::*;

    logic                   pin_s;
    logic [NUM_KINDS-1:0]   kind_act;
    logic [NUM_KINDS-1:0]   kind_end;
    logic [WID_W-1:0]       kind_len [NUM_KINDS];
    logic                   same_pol;
    logic                   frame_evt;
    logic                   line_evt;
    logic                   err_q;

    // Bring the wire into the clock domain; idle is the frame inactive level.
    te_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_lvl (~vs_pol_high),
        .din      (te_in),
        .dout     (pin_s)
    );

    // Qualify the synchronised wire against each pulse kind's active level.
    assign kind_act[KIND_FRAME] = (pin_s == vs_pol_high);
    assign kind_act[KIND_LINE]  = (pin_s == hs_pol_high);
    assign same_pol             = (vs_pol_high == hs_pol_high);

    genvar gk;
    generate
        for (gk = 0; gk < NUM_KINDS; gk++) begin : g_meter
            te_pulse_meter #(.CW(WID_W)) u_meter (
                .clk     (clk),
                .rst_n   (rst_n),
                .active  (kind_act[gk]),
                .end_vld (kind_end[gk]),
                .end_len (kind_len[gk])
            );
        end
    endgenerate

    // Classify finished runs: long enough is a frame, else a line if it
    // clears the line threshold and is not also a frame run.
    assign frame_evt = kind_end[KIND_FRAME] && (kind_len[KIND_FRAME] >= vs_width);
    assign line_evt  = kind_end[KIND_LINE] && (kind_len[KIND_LINE] >= hs_width)
                       && !(same_pol && (kind_len[KIND_LINE] >= vs_width));

    te_cfg_check #(.CW(WID_W)) u_check (
        .clk   (clk),
        .rst_n (rst_n),
        .hs_w  (hs_width),
        .vs_w  (vs_width),
        .mode  (trig_mode),
        .err_q (err_q)
    );

    te_line_tracker #(.LW(LINE_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_evt (frame_evt),
        .line_evt  (line_evt),
        .mode      (trig_mode),
        .target    (target_line),
        .err_q     (err_q),
        .trig_q    (frame_trigger),
        .cnt_q     (line_count)
    );

    assign cfg_error = err_q;

    // With equal polarities a run is never both kinds at once (R2, R3).
    assert_kind_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (same_pol && frame_evt) |-> !line_evt);
endmodule

// File: tb/te_line_sync_tb_top.sv
`timescale 1ns/1ps
module te_line_sync_tb_top;
    localparam int LW = 11;
    localparam int LMAX = 2047;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          te_in = 1'b0;
    logic          vs_pol_high = 1'b1;
    logic          hs_pol_high = 1'b1;
    logic [1:0]    trig_mode = 2'd1;
    logic [7:0]    hs_width = 8'd3;
    logic [7:0]    vs_width = 8'd8;
    logic [LW-1:0] target_line = '0;
    logic          frame_trigger;
    logic [LW-1:0] line_count;
    logic          cfg_error;

    int n_checks = 0;
    int n_fails = 0;
    int exp_cnt = 0;
    int exp_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    te_line_sync dut_i (
        .clk(clk), .rst_n(rst_n), .te_in(te_in),
        .vs_pol_high(vs_pol_high), .hs_pol_high(hs_pol_high),
        .trig_mode(trig_mode), .hs_width(hs_width), .vs_width(vs_width),
        .target_line(target_line), .frame_trigger(frame_trigger),
        .line_count(line_count), .cfg_error(cfg_error)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_err(input int hs, input int vs, input int md);
        int minv;
        minv = (md == 1) ? 4 : 2;
        return ((hs < 2) || (vs < minv) || (hs == vs)) ? 1 : 0;
    endfunction

    // Model one pulse; returns the number of triggers expected from it.
    task automatic model_pulse(input int len, output int trig);
        int err;
        err = exp_err(hs_width, vs_width, trig_mode);
        trig = 0;
        if (len >= vs_width) begin
            exp_cnt = 0;
            exp_seen = 1;
            if (!err && trig_mode == 1 && target_line == 0) trig = 1;
        end else if (len >= hs_width) begin
            if (exp_cnt < LMAX) begin
                if (!err && exp_seen && trig_mode != 0 && exp_cnt + 1 == target_line) trig = 1;
                exp_cnt++;
            end
        end
    endtask

    // Drive one active run then an idle gap; count trigger cycles seen.
    task automatic drive_pulse(input int len, input int gap, output int trig_n);
        trig_n = 0;
        te_in = vs_pol_high;
        repeat (len) begin @(negedge clk); trig_n += frame_trigger; end
        te_in = ~vs_pol_high;
        repeat (gap) begin @(negedge clk); trig_n += frame_trigger; end
    endtask

    task automatic run_pulse(input int len, input int gap, input string tag);
        int et;
        int at;
        model_pulse(len, et);
        drive_pulse(len, gap, at);
        check({tag, " trigger"}, at, et);
        check({tag, " line_count"}, int'(line_count), exp_cnt);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        te_in = ~vs_pol_high;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        exp_seen = 0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input int hs, input int vs, input int md, input int tgt);
        hs_width = 8'(hs);
        vs_width = 8'(vs);
        trig_mode = 2'(md);
        target_line = LW'(tgt);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int at;
        process::self().srandom(32'd1234);
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 trigger in reset", frame_trigger, 0);
        check("R1 line_count in reset", int'(line_count), 0);
        check("R1 error in reset", cfg_error, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line_count after release", int'(line_count), 0);
        exp_cnt = 0; exp_seen = 0;

        // R12 exact latency, R7 frame trigger at target 0, R9 single cycle
        set_cfg(3, 8, 1, 0);
        check("R10 legal config", cfg_error, 0);
        te_in = 1'b1;
        repeat (10) @(negedge clk);
        te_in = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check($sformatf("R12 trigger after edge %0d", k), frame_trigger, (k == 4) ? 1 : 0);
        end
        exp_cnt = 0; exp_seen = 1;
        check("R2 frame clears", int'(line_count), 0);

        // R3/R7: line pulses up to target 3 in mode 1
        set_cfg(3, 8, 1, 3);
        run_pulse(10, 6, "R2 frame");
        for (int i = 0; i < 5; i++) run_pulse(4, 6, "R7 mode1 line");
        // R4: glitch ignored
        run_pulse(2, 6, "R4 glitch");
        run_pulse(1, 6, "R4 glitch one");
        // R8 mode 2, target 0 never; target 2 fires
        set_cfg(3, 8, 2, 0);
        run_pulse(9, 6, "R8 frame target0");
        run_pulse(3, 6, "R8 line target0");
        set_cfg(3, 8, 3, 2);
        run_pulse(9, 6, "R8 frame");
        run_pulse(5, 6, "R8 line1");
        run_pulse(5, 6, "R8 line2");
        run_pulse(5, 6, "R9 line3");
        // R6 internal mode
        set_cfg(3, 8, 0, 0);
        run_pulse(12, 6, "R6 frame");
        set_cfg(3, 8, 0, 1);
        run_pulse(3, 6, "R6 line");

        // R10 error settings
        set_cfg(5, 5, 1, 0);
        check("R10 equal widths", cfg_error, 1);
        run_pulse(6, 6, "R10 frame blocked");
        set_cfg(2, 3, 1, 0);
        check("R10 mode1 short frame", cfg_error, 1);
        set_cfg(2, 3, 2, 1);
        check("R10 mode2 frame 3 ok", cfg_error, 0);
        set_cfg(1, 6, 2, 1);
        check("R10 short line", cfg_error, 1);
        run_pulse(8, 6, "R10 frame");
        run_pulse(2, 6, "R10 line blocked");
        set_cfg(2, 6, 2, 2);
        check("R10 corrected", cfg_error, 0);
        run_pulse(3, 6, "R10 line after fix");

        // R5 active-low wire
        vs_pol_high = 1'b0; hs_pol_high = 1'b0;
        do_reset();
        set_cfg(3, 7, 1, 2);
        run_pulse(8, 6, "R5 low frame");
        run_pulse(4, 6, "R5 low line1");
        run_pulse(4, 6, "R5 low line2");
        vs_pol_high = 1'b1; hs_pol_high = 1'b1;

        // R11 no trigger before a frame pulse
        do_reset();
        set_cfg(3, 8, 2, 1);
        run_pulse(4, 6, "R11 line before frame");
        check("R11 count before frame", int'(line_count), 1);
        run_pulse(9, 6, "R11 frame");
        run_pulse(4, 6, "R11 line after frame");

        // R3 saturation at 2047 with target at the top
        set_cfg(2, 4, 2, LMAX);
        run_pulse(5, 6, "R3 sat frame");
        at = 0;
        for (int i = 0; i < LMAX + 3; i++) begin
            int et;
            int t;
            model_pulse(2, et);
            drive_pulse(2, 6, t);
            at += t;
        end
        check("R3 saturated count", int'(line_count), LMAX);
        check("R9 one trigger over saturation run", at, 1);

        // Random phase against the bench model
        for (int blk = 0; blk < 8; blk++) begin
            int hs;
            int vs;
            int md;
            md = int'($urandom_range(0, 3));
            hs = int'($urandom_range(2, 6));
            vs = hs + int'($urandom_range(1, 10));
            if (md == 1 && vs < 4) vs = 4;
            set_cfg(hs, vs, md, int'($urandom_range(0, 6)));
            check("R10 random legal", cfg_error, 0);
            for (int p = 0; p < 40; p++) begin
                int len;
                len = int'($urandom_range(1, vs + 3));
                if (p % 9 == 0) len = vs + int'($urandom_range(0, 4));
                run_pulse(len, int'($urandom_range(6, 9)), "R3 R7 R8 random");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule